// File: doc/BRIEF.md
# Time-of-Day Counter Core with Rounding Seconds Reset

This block keeps 24-hour time of day from a fast system clock. A prescaler divides the system clock down to a one-cycle enable once per second. That enable drives a chain of three binary counters: seconds, minutes and hours. Each count leaves the block as its own 6-bit value, ready for whatever display or status path sits downstream.

Three active-low push buttons adjust the time. The seconds button clears the seconds and rounds to the nearest minute: from 30 seconds up it also adds one minute. The minute button steps the minutes on their own. The hour button steps the hours. Each button is sampled on the system clock, and only its pressing edge acts, so holding a button down gives exactly one step. There are no ripple clocks: every counter steps on the system clock edge, qualified by single-cycle enables. Debouncing and display decoding belong to the surrounding logic.

Top module: `tod_clock_core`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the prescaler and all three counts clear to zero.
- R2: The seconds count advances by one every TICK_DIV system clock cycles. The first advance after reset is visible after the TICK_DIV-th rising edge following the release of reset.
- R3: Seconds count 0 to 59. When a tick finds seconds at 59, seconds go to 0 and minutes advance by one in the same edge.
- R4: When minutes wrap from 59 to 0 because of a seconds carry, hours advance by one in the same edge. Hours count 0 to 23 and wrap from 23 to 0.
- R5: A seconds-reset press while seconds are 30 or more sets seconds to 0 and advances minutes by one, with the normal carry into hours from 59.
- R6: A seconds-reset press while seconds are below 30 sets seconds to 0 and leaves minutes unchanged.
- R7: A minute-set press advances minutes by one. From 59 it wraps to 0 and leaves hours unchanged.
- R8: An hour-set press advances hours by one, wrapping from 23 to 0.
- R9: Buttons are active-low (0 = pressed). With the default of one sampling stage, a button that goes low before rising edge k acts at rising edge k+1. A button held low for any number of cycles acts only once, and it must return high before it can act again.
- R10: A seconds carry and a minute-set press in the same cycle advance minutes by exactly one.
- R11: A seconds-reset press in the same cycle as a tick wins: seconds become 0, and that tick does not advance them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_rst_n | input | 1 | Seconds reset with rounding, active low |
| min_set_n | input | 1 | Minute-set button, active low |
| hr_set_n | input | 1 | Hour-set button, active low |
| seconds | output | CNT_W | Seconds count, binary, 0 to 59 |
| minutes | output | CNT_W | Minutes count, binary, 0 to 59 |
| hours | output | CNT_W | Hours count, binary, 0 to 23 |

## Verification
The assertions assume the button inputs are already clean and synchronous levels. They also assume that every change of a count comes from the internal press pulses or the tick, so a step of more than one is treated as a fault. The stimulus meets these assumptions by changing button levels only on the falling clock edge. Directed sequences line up a press with a tick, or with a carry, by watching the bench's own model of the prescaler phase. The random phase flips each button with low probability, which produces long holds, one-cycle taps and overlapping presses.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int unsigned SEC_MOD   = 60;
   localparam int unsigned MIN_MOD   = 60;
   localparam int unsigned HR_MOD    = 24;
   localparam int unsigned ROUND_AT  = SEC_MOD / 2;
   localparam int unsigned NUM_BTN   = 3;

   typedef enum int unsigned {
      BTN_SEC = 0,
      BTN_MIN = 1,
      BTN_HR  = 2
   } btn_idx_e;
endpackage

// File: rtl/tod_tick_div.sv
module tod_tick_div #(
   parameter int unsigned DIVIDE = 27_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned W = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
   localparam logic [W-1:0] LAST = W'(DIVIDE - 1);

   generate
      if (DIVIDE < 2) begin : g_bad_div
         $error("tod_tick_div: DIVIDE must be at least 2");
      end
   endgenerate

   logic [W-1:0] phase;

   assign tick = (phase == LAST);

   always_ff @(posedge clk) begin
      if (rst)       phase <= '0;
      else if (tick) phase <= '0;
      else           phase <= phase + W'(1);
   end
endmodule

// File: rtl/tod_btn_edge.sv
module tod_btn_edge #(
   parameter int unsigned N           = 3,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] btn_n,
   output logic [N-1:0] press
);
   generate
      if (N < 1) begin : g_bad_n
         $error("tod_btn_edge: N must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("tod_btn_edge: SYNC_STAGES above 4 is not supported");
      end

      for (genvar i = 0; i < N; i++) begin : g_btn
         logic level;
         logic level_q;

         if (SYNC_STAGES == 0) begin : g_direct
            assign level = btn_n[i];
         end else begin : g_sampled
            logic [SYNC_STAGES-1:0] stage;
            always_ff @(posedge clk) begin
               if (rst) stage <= '1;
               else     stage <= SYNC_STAGES'({stage, btn_n[i]});
            end
            assign level = stage[SYNC_STAGES-1];
         end

         always_ff @(posedge clk) begin
            if (rst) level_q <= 1'b1;
            else     level_q <= level;
         end

         assign press[i] = level_q & ~level;
      end
   endgenerate
endmodule

// File: rtl/tod_wrap_counter.sv
module tod_wrap_counter #(
   parameter int unsigned MODULUS = 60,
   parameter int unsigned W       = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clear,
   input  logic         step,
   output logic [W-1:0] count,
   output logic         at_last
);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   generate
      if (MODULUS < 2 || MODULUS > (1 << W)) begin : g_bad_mod
         $error("tod_wrap_counter: MODULUS must be in 2..2**W");
      end
   endgenerate

   assign at_last = (count == LAST);

   always_ff @(posedge clk) begin
      if (rst)                count <= '0;
      else if (clear)         count <= '0;
      else if (step) begin
         if (at_last)         count <= '0;
         else                 count <= count + W'(1);
      end
   end
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
   import tod_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 27_000_000,
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sec_rst_n,
   input  logic             min_set_n,
   input  logic             hr_set_n,
   output logic [CNT_W-1:0] seconds,
   output logic [CNT_W-1:0] minutes,
   output logic [CNT_W-1:0] hours
);
   localparam logic [CNT_W-1:0] ROUND_LIM = CNT_W'(ROUND_AT);

   generate
      if (CNT_W < 6) begin : g_bad_width
         $error("tod_clock_core: CNT_W must be at least 6");
      end
   endgenerate

   logic               tick;
   logic [NUM_BTN-1:0] btn_n;
   logic [NUM_BTN-1:0] press;
   logic               press_sec, press_min, press_hr;
   logic               sec_last, min_last, hr_last;
   logic               sec_carry, min_step, min_carry, hr_step;

   assign btn_n[BTN_SEC] = sec_rst_n;
   assign btn_n[BTN_MIN] = min_set_n;
   assign btn_n[BTN_HR]  = hr_set_n;

   tod_tick_div #(.DIVIDE(TICK_DIV)) u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   tod_btn_edge #(.N(NUM_BTN), .SYNC_STAGES(SYNC_STAGES)) u_btn (
      .clk   (clk),
      .rst   (rst),
      .btn_n (btn_n),
      .press (press)
   );

   assign press_sec = press[BTN_SEC];
   assign press_min = press[BTN_MIN];
   assign press_hr  = press[BTN_HR];

   // Rounding press overrides the tick; otherwise carry on 59 -> 0.
   assign sec_carry = press_sec ? (seconds >= ROUND_LIM) : (tick & sec_last);
   assign min_step  = sec_carry | press_min;
   // Only a seconds-driven wrap of minutes reaches the hours.
   assign min_carry = sec_carry & min_last;
   assign hr_step   = min_carry | press_hr;

   tod_wrap_counter #(.MODULUS(SEC_MOD), .W(CNT_W)) u_sec (
      .clk     (clk),
      .rst     (rst),
      .clear   (press_sec),
      .step    (tick),
      .count   (seconds),
      .at_last (sec_last)
   );

   tod_wrap_counter #(.MODULUS(MIN_MOD), .W(CNT_W)) u_min (
      .clk     (clk),
      .rst     (rst),
      .clear   (1'b0),
      .step    (min_step),
      .count   (minutes),
      .at_last (min_last)
   );

   tod_wrap_counter #(.MODULUS(HR_MOD), .W(CNT_W)) u_hr (
      .clk     (clk),
      .rst     (rst),
      .clear   (1'b0),
      .step    (hr_step),
      .count   (hours),
      .at_last (hr_last)
   );

   logic unused_ok;
   assign unused_ok = hr_last;
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker #(
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             press_sec,
   input logic             press_min,
   input logic             press_hr,
   input logic [CNT_W-1:0] seconds,
   input logic [CNT_W-1:0] minutes,
   input logic [CNT_W-1:0] hours
);
   localparam logic [CNT_W-1:0] C1  = CNT_W'(1);
   localparam logic [CNT_W-1:0] C23 = CNT_W'(23);
   localparam logic [CNT_W-1:0] C24 = CNT_W'(24);
   localparam logic [CNT_W-1:0] C30 = CNT_W'(30);
   localparam logic [CNT_W-1:0] C59 = CNT_W'(59);
   localparam logic [CNT_W-1:0] C60 = CNT_W'(60);

   p_sec_step_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(seconds) |-> (seconds == '0) || (seconds == $past(seconds) + C1));

   p_sec_range_r3: assert property (@(posedge clk) disable iff (rst)
      seconds < C60);

   p_hr_range_r4: assert property (@(posedge clk) disable iff (rst)
      hours < C24);

   p_round_up_r5: assert property (@(posedge clk) disable iff (rst)
      (press_sec && seconds >= C30) |=> (seconds == '0) && !$stable(minutes));

   p_round_down_r6: assert property (@(posedge clk) disable iff (rst)
      (press_sec && seconds < C30 && !press_min) |=> (seconds == '0) && $stable(minutes));

   p_min_set_no_hr_r7: assert property (@(posedge clk) disable iff (rst)
      (press_min && !press_hr && !press_sec && minutes == C59 && seconds != C59)
      |=> (minutes == '0) && $stable(hours));

   p_hr_step_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(hours) |-> (hours == $past(hours) + C1) || (hours == '0 && $past(hours) == C23));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      press_min |=> !press_min);
endmodule

bind tod_clock_core tod_clock_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .press_sec (press_sec),
   .press_min (press_min),
   .press_hr  (press_hr),
   .seconds   (seconds),
   .minutes   (minutes),
   .hours     (hours)
);

// File: tb/tb_tod_clock_core.sv
module tb_tod_clock_core;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sec_rst_n = 1'b1, min_set_n = 1'b1, hr_set_n = 1'b1;
   logic [5:0] seconds, minutes, hours;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   string tag = "R1";

   always #2 clk = ~clk;

   tod_clock_core #(.TICK_DIV(DIV), .CNT_W(6), .SYNC_STAGES(1)) dut (
      .clk(clk), .rst(rst), .sec_rst_n(sec_rst_n), .min_set_n(min_set_n),
      .hr_set_n(hr_set_n), .seconds(seconds), .minutes(minutes), .hours(hours)
   );

   // Bench reference model written from the requirements
   int m_div = 0, m_sec = 0, m_min = 0, m_hr = 0;
   logic [2:0] m_s1 = 3'b111, m_s2 = 3'b111;

   function automatic int inc_mod(int v, int m);
      return (v == m - 1) ? 0 : v + 1;
   endfunction

   always @(posedge clk) begin
      logic t, ps, pm, ph, sc, mc;
      if (rst) begin
         m_div <= 0; m_sec <= 0; m_min <= 0; m_hr <= 0;
         m_s1 <= 3'b111; m_s2 <= 3'b111;
      end else begin
         t  = (m_div == DIV - 1);
         ps = m_s2[0] & ~m_s1[0];
         pm = m_s2[1] & ~m_s1[1];
         ph = m_s2[2] & ~m_s1[2];
         sc = ps ? (m_sec >= 30) : (t && m_sec == 59);
         mc = sc && (m_min == 59);
         m_div <= t ? 0 : m_div + 1;
         m_sec <= ps ? 0 : (t ? inc_mod(m_sec, 60) : m_sec);
         m_min <= (sc || pm) ? inc_mod(m_min, 60) : m_min;
         m_hr  <= (mc || ph) ? inc_mod(m_hr, 24) : m_hr;
         m_s2 <= m_s1;
         m_s1 <= {hr_set_n, min_set_n, sec_rst_n};
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         check(tag, "seconds vs model", int'(seconds), m_sec);
         check(tag, "minutes vs model", int'(minutes), m_min);
         check(tag, "hours vs model",   int'(hours),   m_hr);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic set_btn(int idx, logic v);
      case (idx)
         0: sec_rst_n = v;
         1: min_set_n = v;
         default: hr_set_n = v;
      endcase
   endtask

   task automatic press(int idx, int hold, int gap);
      set_btn(idx, 1'b0);
      repeat (hold) @(negedge clk);
      set_btn(idx, 1'b1);
      repeat (gap) @(negedge clk);
   endtask

   task automatic wait_until_sec(int s);
      while (int'(seconds) != s) @(negedge clk);
   endtask

   initial begin
      int c, m, h, n;
      void'($urandom(32'd20240611));
      @(negedge clk);
      repeat (4) @(negedge clk);
      // R1: counts cleared during reset
      check("R1", "seconds in reset", int'(seconds), 0);
      check("R1", "minutes in reset", int'(minutes), 0);
      check("R1", "hours in reset",   int'(hours),   0);
      rst = 1'b0;

      // R2: first tick after TICK_DIV edges
      tag = "R2"; c = 0;
      while (seconds == 0) begin @(negedge clk); c++; end
      check("R2", "cycles to first second", c, DIV);

      // R3: seconds wrap carries into minutes
      tag = "R3";
      wait_until_sec(59); m = int'(minutes);
      wait_until_sec(0);
      check("R3", "minutes after 59->0", int'(minutes), (m + 1) % 60);

      // R5: rounding up
      tag = "R5";
      while (!(seconds == 40 && m_div == 0)) @(negedge clk);
      m = int'(minutes);
      sec_rst_n = 1'b0; @(negedge clk); sec_rst_n = 1'b1; @(negedge clk);
      check("R5", "seconds after round up", int'(seconds), 0);
      check("R5", "minutes after round up", int'(minutes), (m + 1) % 60);

      // R6: rounding down
      tag = "R6";
      while (!(seconds == 20 && m_div == 0)) @(negedge clk);
      m = int'(minutes);
      sec_rst_n = 1'b0; @(negedge clk); sec_rst_n = 1'b1; @(negedge clk);
      check("R6", "seconds after round down", int'(seconds), 0);
      check("R6", "minutes after round down", int'(minutes), m);

      // R9: held button steps once
      tag = "R9";
      wait_until_sec(1); m = int'(minutes);
      press(1, 20, 3);
      check("R9", "minutes after long hold", int'(minutes), (m + 1) % 60);

      // R7 / R8: fast setting to 23:59, then wraps
      tag = "R7";
      wait_until_sec(1);
      m = int'(minutes); h = int'(hours);
      n = (59 - m + 60) % 60;
      for (int i = 0; i < n; i++) press(1, 1, 1);
      n = (23 - h + 24) % 24;
      for (int i = 0; i < n; i++) press(2, 1, 1);
      repeat (2) @(negedge clk);
      check("R7", "minutes set to 59", int'(minutes), 59);
      check("R8", "hours set to 23",   int'(hours),   23);
      press(1, 1, 3);
      check("R7", "minutes wrap by set", int'(minutes), 0);
      check("R7", "hours untouched by minute wrap", int'(hours), 23);
      tag = "R8";
      press(2, 1, 3);
      check("R8", "hours wrap by set", int'(hours), 0);

      // R4: seconds carry ripples through 23:59:59
      tag = "R4";
      wait_until_sec(1);
      m = int'(minutes); h = int'(hours);
      n = (59 - m + 60) % 60;
      for (int i = 0; i < n; i++) press(1, 1, 1);
      n = (23 - h + 24) % 24;
      for (int i = 0; i < n; i++) press(2, 1, 1);
      repeat (2) @(negedge clk);
      check("R4", "minutes preset", int'(minutes), 59);
      check("R4", "hours preset",   int'(hours),   23);
      wait_until_sec(59);
      wait_until_sec(0);
      check("R4", "minutes after day wrap", int'(minutes), 0);
      check("R4", "hours after day wrap",   int'(hours),   0);

      // R10: seconds carry and minute set together
      tag = "R10";
      while (!(seconds == 59 && m_div == DIV - 2)) @(negedge clk);
      m = int'(minutes);
      min_set_n = 1'b0; @(negedge clk); min_set_n = 1'b1; @(negedge clk);
      check("R10", "minutes on coincident carry and set", int'(minutes), (m + 1) % 60);
      check("R10", "seconds on coincident carry and set", int'(seconds), 0);

      // R11: seconds reset beats a tick in the same cycle
      tag = "R11";
      while (!(seconds == 10 && m_div == DIV - 2)) @(negedge clk);
      m = int'(minutes);
      sec_rst_n = 1'b0; @(negedge clk); sec_rst_n = 1'b1; @(negedge clk);
      check("R11", "seconds when reset meets tick", int'(seconds), 0);
      check("R11", "minutes when reset meets tick", int'(minutes), m);

      // Random button activity, every cycle checked against the model (R9)
      tag = "R9";
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(7) == 0) sec_rst_n = ~sec_rst_n;
         if ($urandom_range(5) == 0) min_set_n = ~min_set_n;
         if ($urandom_range(5) == 0) hr_set_n  = ~hr_set_n;
         @(negedge clk);
      end
      sec_rst_n = 1'b1; min_set_n = 1'b1; hr_set_n = 1'b1;
      repeat (4) @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule